// File: doc/BRIEF.md
# Write Protect and Block Lock Controller

This block decides whether writes reach an 8K x 8 nonvolatile byte memory, and whether writes to its protection register take effect. The protection register sits at the top address of the map. It holds two volatile enable latches and three nonvolatile bits. The nonvolatile bits are a lock field that protects an upper region of the array and a hardware-protect enable bit. The surrounding serial protocol engine reports four kinds of event to the block, each as a one-cycle pulse: bus start, bus stop, a data byte aimed at the register, and a data byte aimed at the array together with its 13-bit address.

For each data byte the block returns an acknowledge decision in the same cycle. When a stop arrives it states whether a nonvolatile programming cycle may begin. The register contents are always visible as a readback byte, and the current nonvolatile bits are driven out separately so that they can be stored.

Changing the lock bits takes three steps: set the write latch, set the register latch, then program. Writes to locked addresses are acknowledged and then discarded. When the protect pin is high and the enable bit is set, the lock bits become permanent.

The nonvolatile bits are flops that take parameter-defined initial values when `nvInitN` is asserted. The volatile power-on reset `porN` leaves them untouched. Every state change takes effect on the clock edge of a stop event.

Top module: `wpLockCtrl`

## Requirements
- R1: While `porN` is low, the write latch and the register latch clear to 0. The lock field and the enable bit keep their values through `porN`, and `nvInitN` low loads them from the parameters (both default to 0).
- R2: The readback byte is laid out as bit 7 = enable, bits 4:3 = lock field, bit 2 = register latch, bit 1 = write latch. Bits 6, 5 and 0 always read 0.
- R3: While the write latch is 0, an array data byte is not acknowledged, and the stop that follows gives `commitOk` = 0.
- R4: With the register latch at 0, register byte 0x02 sets the write latch and 0x00 clears it. Any register change becomes visible only after the edge of the stop cycle.
- R5: With the write latch at 1 and the register latch at 0, byte 0x06 sets the register latch. While the register latch is 1, the write latch never clears, and byte 0x00 leaves the register unchanged.
- R6: With the register latch at 1, a byte of the form u00xy010 is acknowledged. At its stop, `commitOk` = 1, the enable bit becomes u and the lock field becomes xy, the register latch clears and the write latch stays at 1.
- R7: With the register latch at 1, a byte that has bit 2 set, or that has bit 1 clear, changes nothing. A start that comes before the stop cancels a pending programming step, and the register latch stays at 1.
- R8: The lock field protects addresses as follows: 00 protects nothing, 01 protects 1800h–1FFFh, 10 protects 1000h–1FFFh and 11 protects the whole array. A byte aimed at a protected address is still acknowledged when the write latch is 1, but its stop gives `commitOk` = 0.
- R9: An array byte aimed at an unprotected address, with the write latch at 1, is acknowledged. Its stop gives `commitOk` = 1 and clears the register latch.
- R10: With `wpPin` high and the enable bit at 1, a programming step is acknowledged but its stop gives `commitOk` = 0, and the enable bit and the lock field cannot change. The volatile latches and unprotected array bytes can still be written.
- R11: A register byte with a nonzero bit 6, 5 or 0 is not acknowledged and changes nothing. Only the first register byte after a start can be acknowledged.
- R12: `ackOk` is combinational and valid only in the cycle of a data-byte event; otherwise it is 0. `commitOk` can be 1 only in the cycle of a stop event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Volatile power-on reset, active low, asynchronous |
| nvInitN | input | 1 | Loads the nonvolatile bits from their parameters, active low |
| wpPin | input | 1 | Hardware write-protect pin |
| startEv | input | 1 | Bus start seen (one-cycle pulse) |
| stopEv | input | 1 | Bus stop seen (one-cycle pulse) |
| regWrEv | input | 1 | Data byte for the protection register |
| arrWrEv | input | 1 | Data byte for the array |
| dataByte | input | 8 | Data byte presented with either event |
| arrAddr | input | 13 | Array byte address presented with `arrWrEv` |
| ackOk | output | 1 | Acknowledge decision for the presented data byte |
| commitOk | output | 1 | A nonvolatile programming cycle may start at this stop |
| regRdByte | output | 8 | Protection register readback |
| nvWpen | output | 1 | Current nonvolatile enable bit |
| nvBl | output | 2 | Current nonvolatile lock field |

## Verification
`ackOk` is due in the same cycle as its data-byte event, and `commitOk` in the same cycle as its stop event. The bench therefore drives each event at a falling edge and samples these outputs 2 ns later, before the capturing rising edge. Register and nonvolatile outputs change on the rising edge of the stop cycle. The bench reads them at the next falling edge and never earlier. Two sweeps cover most of the behaviour. One sends all 256 register bytes from each of the three latch stages and checks the results against arithmetic expectations. The other tries every lock setting against addresses spread across the array.

// File: rtl/wpPkg.sv
package wpPkg;

  // Bit positions in the protection register.
  localparam int BIT_WPEN = 7;
  localparam int BIT_BLH  = 4;
  localparam int BIT_BLL  = 3;
  localparam int BIT_RWEL = 2;
  localparam int BIT_WEL  = 1;
  localparam logic [7:0] RES_MASK = 8'h61;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_WEL,
    OP_CLR_WEL,
    OP_SET_RWEL,
    OP_PROG,
    OP_ARRAY
  } wpOpE;

  typedef struct packed {
    logic       setWel;
    logic       clrWel;
    logic       setRwel;
    logic       clrRwel;
    logic       loadNv;
    logic       newWpen;
    logic [1:0] newBl;
  } wpStrobeT;

endpackage

// File: rtl/wpCtrl.sv
module wpCtrl
  import wpPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              wpPin,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              regWrEv,
  input  logic              arrWrEv,
  input  logic [7:0]        dataByte,
  input  logic [ADDR_W-1:0] arrAddr,
  input  logic              curWel,
  input  logic              curRwel,
  input  logic              curWpen,
  input  logic [1:0]        curBl,
  output logic              ackOk,
  output logic              commitOk,
  output wpStrobeT          strobe
);

  wpOpE       pendOp;
  logic       pendWpen;
  logic [1:0] pendBl;
  logic       byteSeen;

  logic resOk, hwLock, regAck, arrAck, addrLocked;
  wpOpE regOp;

  assign resOk  = (dataByte & RES_MASK) == 8'h00;
  assign hwLock = wpPin && curWpen;
  assign regAck = resOk && !byteSeen;
  assign arrAck = curWel;

  // Upper-region decode on the top address bits.
  always_comb begin
    unique case (curBl)
      2'b00:   addrLocked = 1'b0;
      2'b01:   addrLocked = (arrAddr[ADDR_W-1 -: 2] == 2'b11);
      2'b10:   addrLocked = arrAddr[ADDR_W-1];
      default: addrLocked = 1'b1;
    endcase
  end

  // Register byte decode against the current latch stage.
  always_comb begin
    regOp = OP_NONE;
    if (curRwel) begin
      if (!dataByte[BIT_RWEL] && dataByte[BIT_WEL]) regOp = OP_PROG;
    end else if (dataByte == 8'h02) begin
      regOp = OP_SET_WEL;
    end else if (dataByte == 8'h00) begin
      regOp = OP_CLR_WEL;
    end else if (dataByte == 8'h06 && curWel) begin
      regOp = OP_SET_RWEL;
    end
  end

  always_comb begin
    if (regWrEv)      ackOk = regAck;
    else if (arrWrEv) ackOk = arrAck;
    else              ackOk = 1'b0;
  end

  assign commitOk = stopEv &&
                    ((pendOp == OP_ARRAY) || ((pendOp == OP_PROG) && !hwLock));

  always_comb begin
    strobe         = '0;
    strobe.newWpen = pendWpen;
    strobe.newBl   = pendBl;
    if (stopEv) begin
      strobe.setWel  = (pendOp == OP_SET_WEL);
      strobe.clrWel  = (pendOp == OP_CLR_WEL);
      strobe.setRwel = (pendOp == OP_SET_RWEL);
      strobe.loadNv  = commitOk && (pendOp == OP_PROG);
      strobe.clrRwel = commitOk;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      pendOp   <= OP_NONE;
      pendWpen <= 1'b0;
      pendBl   <= 2'b00;
      byteSeen <= 1'b0;
    end else if (startEv || stopEv) begin
      pendOp   <= OP_NONE;
      byteSeen <= 1'b0;
    end else if (regWrEv) begin
      byteSeen <= 1'b1;
      if (!byteSeen) begin
        pendOp   <= resOk ? regOp : OP_NONE;
        pendWpen <= dataByte[BIT_WPEN];
        pendBl   <= dataByte[BIT_BLH:BIT_BLL];
      end
    end else if (arrWrEv) begin
      byteSeen <= 1'b1;
      if (curWel && !addrLocked) pendOp <= OP_ARRAY;
    end
  end

endmodule

// File: rtl/wpRegs.sv
module wpRegs
  import wpPkg::*;
#(
  parameter logic       INIT_WPEN = 1'b0,
  parameter logic [1:0] INIT_BL   = 2'b00
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       nvInitN,
  input  wpStrobeT   strobe,
  output logic       curWel,
  output logic       curRwel,
  output logic       curWpen,
  output logic [1:0] curBl,
  output logic [7:0] regRdByte
);

  // Volatile latches.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      curWel  <= 1'b0;
      curRwel <= 1'b0;
    end else begin
      if (strobe.setWel)  curWel  <= 1'b1;
      if (strobe.clrWel)  curWel  <= 1'b0;
      if (strobe.setRwel) curRwel <= 1'b1;
      if (strobe.clrRwel) curRwel <= 1'b0;
    end
  end

  // Nonvolatile bits, untouched by the volatile reset.
  always_ff @(posedge clk or negedge nvInitN) begin
    if (!nvInitN) begin
      curWpen <= INIT_WPEN;
      curBl   <= INIT_BL;
    end else if (strobe.loadNv) begin
      curWpen <= strobe.newWpen;
      curBl   <= strobe.newBl;
    end
  end

  always_comb begin
    regRdByte                  = 8'h00;
    regRdByte[BIT_WPEN]        = curWpen;
    regRdByte[BIT_BLH:BIT_BLL] = curBl;
    regRdByte[BIT_RWEL]        = curRwel;
    regRdByte[BIT_WEL]         = curWel;
  end

endmodule

// File: rtl/wpLockCtrl.sv
module wpLockCtrl
  import wpPkg::*;
#(
  parameter int         ADDR_W    = 13,
  parameter logic       INIT_WPEN = 1'b0,
  parameter logic [1:0] INIT_BL   = 2'b00
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              nvInitN,
  input  logic              wpPin,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              regWrEv,
  input  logic              arrWrEv,
  input  logic [7:0]        dataByte,
  input  logic [ADDR_W-1:0] arrAddr,
  output logic              ackOk,
  output logic              commitOk,
  output logic [7:0]        regRdByte,
  output logic              nvWpen,
  output logic [1:0]        nvBl
);

  wpStrobeT   strobe;
  logic       curWel, curRwel, curWpen;
  logic [1:0] curBl;

  wpCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .porN(porN), .wpPin(wpPin), .startEv(startEv),
    .stopEv(stopEv), .regWrEv(regWrEv), .arrWrEv(arrWrEv),
    .dataByte(dataByte), .arrAddr(arrAddr), .curWel(curWel),
    .curRwel(curRwel), .curWpen(curWpen), .curBl(curBl),
    .ackOk(ackOk), .commitOk(commitOk), .strobe(strobe)
  );

  wpRegs #(.INIT_WPEN(INIT_WPEN), .INIT_BL(INIT_BL)) u_regs (
    .clk(clk), .porN(porN), .nvInitN(nvInitN), .strobe(strobe),
    .curWel(curWel), .curRwel(curRwel), .curWpen(curWpen),
    .curBl(curBl), .regRdByte(regRdByte)
  );

  assign nvWpen = curWpen;
  assign nvBl   = curBl;

endmodule

// File: rtl/wpLockCtrl_chk.sv
module wpLockCtrl_chk (
  input logic       clk,
  input logic       porN,
  input logic       nvInitN,
  input logic       wpPin,
  input logic       stopEv,
  input logic       regWrEv,
  input logic       arrWrEv,
  input logic       ackOk,
  input logic       commitOk,
  input logic [7:0] regRdByte,
  input logic       nvWpen,
  input logic [1:0] nvBl
);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!porN)
    (regRdByte[6:5] == 2'b00) && !regRdByte[0]);

  // R12
  ack_idle_chk: assert property (@(posedge clk) disable iff (!porN)
    !(regWrEv || arrWrEv) |-> !ackOk);

  // R12
  commit_stop_chk: assert property (@(posedge clk) disable iff (!porN)
    !stopEv |-> !commitOk);

  // R3
  arr_nowel_chk: assert property (@(posedge clk) disable iff (!porN)
    (arrWrEv && !regRdByte[1]) |-> !ackOk);

  // R4
  stop_only_chk: assert property (@(posedge clk) disable iff (!porN || !nvInitN)
    !stopEv |=> $stable(regRdByte));

  // R5
  wel_keep_chk: assert property (@(posedge clk) disable iff (!porN)
    regRdByte[2] |=> regRdByte[1]);

  // R9
  rwel_clear_chk: assert property (@(posedge clk) disable iff (!porN)
    commitOk |=> !regRdByte[2]);

  // R10
  hw_hold_chk: assert property (@(posedge clk) disable iff (!porN || !nvInitN)
    (wpPin && nvWpen) |=> (nvWpen && $stable(nvBl)));

endmodule

bind wpLockCtrl wpLockCtrl_chk u_chk (
  .clk(clk), .porN(porN), .nvInitN(nvInitN), .wpPin(wpPin),
  .stopEv(stopEv), .regWrEv(regWrEv), .arrWrEv(arrWrEv),
  .ackOk(ackOk), .commitOk(commitOk), .regRdByte(regRdByte),
  .nvWpen(nvWpen), .nvBl(nvBl)
);

// File: tb/wpLockCtrl_bench.sv
`timescale 1ns/1ps
module wpLockCtrl_bench;

  logic        clk = 1'b0;
  logic        porN = 1'b0, nvInitN = 1'b0, wpPin = 1'b0;
  logic        startEv = 1'b0, stopEv = 1'b0, regWrEv = 1'b0, arrWrEv = 1'b0;
  logic [7:0]  dataByte = 8'h00;
  logic [12:0] arrAddr = '0;
  logic        ackOk, commitOk, nvWpen;
  logic [7:0]  regRdByte;
  logic [1:0]  nvBl;

  int nChk = 0, nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wpLockCtrl u_wpLockCtrl (
    .clk(clk), .porN(porN), .nvInitN(nvInitN), .wpPin(wpPin),
    .startEv(startEv), .stopEv(stopEv), .regWrEv(regWrEv), .arrWrEv(arrWrEv),
    .dataByte(dataByte), .arrAddr(arrAddr), .ackOk(ackOk), .commitOk(commitOk),
    .regRdByte(regRdByte), .nvWpen(nvWpen), .nvBl(nvBl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doPor();
    @(negedge clk); porN = 1'b0;
    @(negedge clk); porN = 1'b1;
  endtask

  task automatic doNvInit();
    @(negedge clk); nvInitN = 1'b0;
    @(negedge clk); nvInitN = 1'b1;
  endtask

  task automatic doStart();
    @(negedge clk); startEv = 1'b1;
    @(negedge clk); startEv = 1'b0;
  endtask

  task automatic sendReg(input logic [7:0] b, output logic a);
    @(negedge clk); dataByte = b; regWrEv = 1'b1;
    #2 a = ackOk;
    @(negedge clk); regWrEv = 1'b0;
  endtask

  task automatic sendArr(input logic [12:0] ad, input logic [7:0] b, output logic a);
    @(negedge clk); dataByte = b; arrAddr = ad; arrWrEv = 1'b1;
    #2 a = ackOk;
    @(negedge clk); arrWrEv = 1'b0;
  endtask

  // Returns at the negedge after the stop edge, so state is already updated.
  task automatic sendStop(output logic c);
    @(negedge clk); stopEv = 1'b1;
    #2 c = commitOk;
    @(negedge clk); stopEv = 1'b0;
  endtask

  task automatic regXfer(input logic [7:0] b, output logic a, output logic c);
    doStart();
    sendReg(b, a);
    sendStop(c);
  endtask

  task automatic arrXfer(input logic [12:0] ad, output logic a, output logic c);
    doStart();
    sendArr(ad, 8'h5A, a);
    sendStop(c);
  endtask

  function automatic bit isLocked(input int bl, input int ad);
    return (bl == 3) || (bl == 2 && ad >= 4096) || (bl == 1 && ad >= 6144);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin : main
    logic a, c, a2;
    logic [7:0] erb;

    repeat (2) @(negedge clk);
    porN = 1'b1; nvInitN = 1'b1;
    @(negedge clk);
    chk(regRdByte == 8'h00, "R1 reset readback", regRdByte, 0);
    @(negedge clk);
    #2 chk(ackOk == 0 && commitOk == 0, "R12 idle outputs", {ackOk, commitOk}, 0);

    // Register byte sweep over the three latch stages.
    for (int st = 0; st < 3; st++) begin
      for (int b = 0; b < 256; b++) begin
        bit resOk, ew, er, ewp, ea, ec;
        logic [1:0] ebl;
        logic [7:0] bb;
        bb = b[7:0];
        doPor(); doNvInit();
        if (st >= 1) regXfer(8'h02, a, c);
        if (st == 2) regXfer(8'h06, a, c);
        resOk = (bb & 8'h61) == 0;
        ew = (st >= 1); er = (st == 2); ewp = 0; ebl = 0; ec = 0; ea = resOk;
        if (resOk) begin
          if (st == 2) begin
            if (!bb[2] && bb[1]) begin ec = 1; ewp = bb[7]; ebl = bb[4:3]; er = 0; end
          end else if (bb == 8'h02) ew = 1;
          else if (bb == 8'h00) ew = 0;
          else if (bb == 8'h06 && st == 1) er = 1;
        end
        erb = {ewp, 2'b00, ebl, er, ew, 1'b0};
        regXfer(bb, a, c);
        if (!resOk)
          chk(a == ea, "R11 reserved bits nack", a, ea);
        else if (st == 2)
          chk(a == ea, "R6 program byte ack", a, ea);
        else
          chk(a == ea, "R4 latch byte ack", a, ea);
        if (st == 2 && ec)
          chk(c == ec && regRdByte == erb, "R6 program commit",
              {c, regRdByte}, {ec, erb});
        else if (st == 2)
          chk(c == ec && regRdByte == erb, "R7 no change", {c, regRdByte}, {ec, erb});
        else if (st == 1)
          chk(c == ec && regRdByte == erb, "R5 stage1 result", {c, regRdByte}, {ec, erb});
        else
          chk(c == ec && regRdByte == erb, "R4 stage0 result", {c, regRdByte}, {ec, erb});
        chk(nvWpen == ewp && nvBl == ebl, "R2 nv outputs", {nvWpen, nvBl}, {ewp, ebl});
      end
    end

    // Nonvolatile bits survive volatile reset.
    doPor(); doNvInit();
    regXfer(8'h02, a, c); regXfer(8'h06, a, c); regXfer(8'h0A, a, c);
    doPor();
    chk(regRdByte == 8'h08, "R1 nv kept through porN", regRdByte, 8'h08);
    doNvInit();
    chk(regRdByte == 8'h00, "R1 nvInitN restores", regRdByte, 0);

    // Array write without write latch.
    arrXfer(13'h0100, a, c);
    chk(a == 0 && c == 0, "R3 array nack without latch", {a, c}, 0);

    // Array write clears register latch.
    regXfer(8'h02, a, c); regXfer(8'h06, a, c);
    arrXfer(13'h0040, a, c);
    chk(a == 1 && c == 1, "R9 unprotected commit", {a, c}, 3);
    chk(regRdByte == 8'h02, "R9 register latch cleared", regRdByte, 8'h02);

    // Start aborts a pending programming step.
    regXfer(8'h06, a, c);
    doStart(); sendReg(8'h1A, a); doStart(); sendStop(c);
    chk(c == 0 && regRdByte == 8'h06, "R7 start abort", {c, regRdByte}, 8'h06);

    // Register latch set: 0x00 leaves everything.
    regXfer(8'h00, a, c);
    chk(regRdByte == 8'h06, "R5 latch clear refused", regRdByte, 8'h06);

    // Second register byte not acknowledged.
    doPor();
    doStart(); sendReg(8'h02, a); sendReg(8'h02, a2); sendStop(c);
    chk(a == 1 && a2 == 0, "R11 second byte nack", {a, a2}, 2);
    chk(regRdByte == 8'h02, "R11 first byte kept", regRdByte, 8'h02);

    // Lock range sweep.
    for (int bl = 0; bl < 4; bl++) begin
      doPor(); doNvInit();
      regXfer(8'h02, a, c); regXfer(8'h06, a, c);
      regXfer(8'((bl << 3) | 2), a, c);
      chk(nvBl == bl[1:0], "R6 lock field programmed", nvBl, bl);
      for (int ad = 0; ad < 8192; ad += 64) begin
        arrXfer(ad[12:0], a, c);
        chk(a == 1, "R8 locked byte still acked", a, 1);
        chk(c == !isLocked(bl, ad), "R8 lock range commit", c, !isLocked(bl, ad));
      end
      arrXfer(13'h1FFF, a, c);
      chk(c == !isLocked(bl, 8191), "R8 top address", c, !isLocked(bl, 8191));
    end

    // Hardware protection.
    doPor(); doNvInit();
    regXfer(8'h02, a, c); regXfer(8'h06, a, c); regXfer(8'h82, a, c);
    chk(nvWpen == 1, "R6 enable bit programmed", nvWpen, 1);
    wpPin = 1'b1;
    regXfer(8'h06, a, c);
    regXfer(8'h1A, a, c);
    chk(a == 1 && c == 0, "R10 programming refused", {a, c}, 2);
    chk(regRdByte == 8'h86, "R10 register unchanged", regRdByte, 8'h86);
    doPor();
    regXfer(8'h02, a, c);
    chk(regRdByte == 8'h82, "R10 latch writable", regRdByte, 8'h82);
    arrXfer(13'h1F00, a, c);
    chk(a == 1 && c == 1, "R10 array writable", {a, c}, 3);
    wpPin = 1'b0;
    regXfer(8'h06, a, c); regXfer(8'h02, a, c);
    chk(c == 1 && nvWpen == 0, "R10 pin low allows clear", {c, nvWpen}, 2);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule